// File: doc/BRIEF.md
# T1 Errored-Second Performance Monitor

This block gathers the error indications that a T1 receive framer and CRC checker produce and turns them into saturating error counters, sticky interrupt-status bits and an errored-second summary. Framing-bit errors and CRC multiframe errors arrive as single-cycle pulses. Loss of frame alignment, loss of signal and the alarm indication signal arrive as levels. A flag tells the block whether the framer is synchronised, a mode bit selects superframe (SF) or extended superframe (ESF) operation, and a one-second tick marks the boundary of each measurement second.

Software reaches the counters, an errored-second mask, an interrupt-enable register and the status bits through a small register port. Reading a counter returns its value and empties it in the same cycle. At every tick the block decides whether the second that just ended was errored, based on the events that the mask admits. It also raises a one-second status bit, which tells software to come and read the results. A single interrupt line is driven by the status bits that are both pending and enabled.

Top module: `t1_es_monitor`

## Requirements
- R1: While `in_sync` is 1, each cycle with `evt_frm_err` high adds one to the framing error counter (address 0), in SF and ESF mode alike.
- R2: The CRC error counter (address 1) adds one per `evt_crc_err` pulse only while `esf_mode` is 1 and `in_sync` is 1; in SF mode (`esf_mode` 0) it does not change.
- R3: While `in_sync` is 0, neither counter changes except by being read.
- R4: A counter that reaches its all-ones value (2^CNT_W-1) stays there on further events until it is read.
- R5: A read (`reg_rd` high) of address 0 or 1 puts the counter value, zero-extended, on `reg_rdata` one cycle later and clears the counter. If a qualifying event arrives in the read cycle, the counter holds 1 afterwards. Reads of addresses 2, 3 and 4 return the ES mask, the interrupt enables and the status bits, and any other address reads 0.
- R6: While `lvl_lof`, `lvl_los` or `lvl_ais` is high, status bit 0, 1 or 2 respectively is set at the next clock edge, and it stays set until cleared.
- R7: The ES mask (address 2) has bit 0 for framing error, bit 1 for CRC error, bit 2 for LOF, bit 3 for LOS and bit 4 for AIS. Framing and CRC errors take part only when they would be counted. At a cycle with `sec_tick` high, status bit 3 (ES) is set if any admitted event occurred since the previous tick, including in the tick cycle itself. The record of events then starts again empty.
- R8: Every cycle with `sec_tick` high sets status bit 4 (one-second).
- R9: Writing address 4 clears each status bit whose write-data bit is 1 and leaves the others. A set condition in the same cycle wins over the clear.
- R10: `irq` is high exactly when some status bit is 1 and its enable bit at address 3 (same bit positions as the status) is also 1.
- R11: After reset, the counters, the mask, the enables, the status, `reg_rdata` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_frm_err | input | 1 | Framing bit error pulse |
| evt_crc_err | input | 1 | CRC multiframe error pulse |
| lvl_lof | input | 1 | Loss of frame alignment level |
| lvl_los | input | 1 | Loss of signal level |
| lvl_ais | input | 1 | Alarm indication signal level |
| in_sync | input | 1 | Framer synchronised (1) or asynchronous (0) |
| esf_mode | input | 1 | 1 = ESF, 0 = SF |
| sec_tick | input | 1 | One-second boundary pulse |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with CNT_W = 4, DATA_W = 16, saturation on and the one-second interrupt on. The narrow counter makes the all-ones limit reachable within a few dozen events, so the random phase saturates counters repeatedly, and a directed case pushes one past its limit. The ticks come every fifty cycles, which puts many second boundaries, mask changes and status clears close to one another within a short run.

// File: rtl/t1_es_pkg.sv
package t1_es_pkg;
   // register addresses
   localparam int A_FEC  = 0;
   localparam int A_CEC  = 1;
   localparam int A_MASK = 2;
   localparam int A_IEN  = 3;
   localparam int A_STAT = 4;

   // event sources for the errored-second mask
   localparam int EV_FRM = 0;
   localparam int EV_CRC = 1;
   localparam int EV_LOF = 2;
   localparam int EV_LOS = 3;
   localparam int EV_AIS = 4;
   localparam int N_SRC  = 5;

   // status / interrupt bits
   localparam int ST_LOF = 0;
   localparam int ST_LOS = 1;
   localparam int ST_AIS = 2;
   localparam int ST_ES  = 3;
   localparam int ST_SEC = 4;
   localparam int N_IRQ  = 5;

   // counter slots
   localparam int C_FRM  = 0;
   localparam int C_CRC  = 1;
   localparam int N_CNT  = 2;
endpackage

// File: rtl/t1_es_err_counter.sv
module t1_es_err_counter #(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;

   if (CNT_W < 2) begin : g_bad_width
      $error("t1_es_err_counter: CNT_W must be at least 2");
   end

   generate
      if (SATURATE) begin : g_sat
         always_comb cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
      end else begin : g_wrap
         always_comb cnt_inc = cnt_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         // snapshot-and-clear keeps an event that lands in the read cycle
         cnt_q <= inc ? CNT_W'(1) : '0;
      end else if (inc) begin
         cnt_q <= cnt_inc;
      end
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/t1_es_accum.sv
module t1_es_accum #(
   parameter int N_SRC = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] evt,
   input  logic [N_SRC-1:0] mask,
   input  logic             tick,
   output logic             es_set
);
   logic seen_q;
   logic hit;

   if (N_SRC < 1) begin : g_bad_src
      $error("t1_es_accum: N_SRC must be at least 1");
   end

   assign hit    = |(evt & mask);
   assign es_set = tick & (seen_q | hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
      end else if (tick) begin
         seen_q <= 1'b0;
      end else if (hit) begin
         seen_q <= 1'b1;
      end
   end
endmodule

// File: rtl/t1_es_irq_ctrl.sv
module t1_es_irq_ctrl #(
   parameter int N_IRQ = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IRQ-1:0] set,
   input  logic [N_IRQ-1:0] clr,
   input  logic [N_IRQ-1:0] en,
   output logic [N_IRQ-1:0] pending,
   output logic             irq
);
   logic [N_IRQ-1:0] pend_q;

   if (N_IRQ < 1) begin : g_bad_irq
      $error("t1_es_irq_ctrl: N_IRQ must be at least 1");
   end

   for (genvar i = 0; i < N_IRQ; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q[i] <= 1'b0;
         end else if (set[i]) begin
            pend_q[i] <= 1'b1;
         end else if (clr[i]) begin
            pend_q[i] <= 1'b0;
         end
      end
   end

   assign pending = pend_q;
   assign irq     = |(pend_q & en);
endmodule

// File: rtl/t1_es_monitor.sv
module t1_es_monitor
   import t1_es_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 3,
   parameter bit SATURATE   = 1'b1,
   parameter bit SEC_IRQ_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_frm_err,
   input  logic              evt_crc_err,
   input  logic              lvl_lof,
   input  logic              lvl_los,
   input  logic              lvl_ais,
   input  logic              in_sync,
   input  logic              esf_mode,
   input  logic              sec_tick,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   localparam int N_REG = A_STAT + 1;

   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("t1_es_monitor: CNT_W must not exceed DATA_W");
   end
   if (DATA_W < N_SRC || DATA_W < N_IRQ) begin : g_bad_data
      $error("t1_es_monitor: DATA_W too narrow for mask/status");
   end
   if ((1 << ADDR_W) < N_REG) begin : g_bad_addr
      $error("t1_es_monitor: ADDR_W too narrow for register map");
   end

   // address decode
   logic sel_fec, sel_cec, sel_mask, sel_ien, sel_stat;
   assign sel_fec  = (reg_addr == ADDR_W'(A_FEC));
   assign sel_cec  = (reg_addr == ADDR_W'(A_CEC));
   assign sel_mask = (reg_addr == ADDR_W'(A_MASK));
   assign sel_ien  = (reg_addr == ADDR_W'(A_IEN));
   assign sel_stat = (reg_addr == ADDR_W'(A_STAT));

   // qualified counting events
   logic frm_q, crc_q;
   assign frm_q = evt_frm_err & in_sync;
   assign crc_q = evt_crc_err & in_sync & esf_mode;

   // error counters
   logic [N_CNT-1:0] cnt_inc;
   logic [N_CNT-1:0] cnt_clr;
   logic [CNT_W-1:0] cnt_q [N_CNT];

   assign cnt_inc[C_FRM] = frm_q;
   assign cnt_inc[C_CRC] = crc_q;
   assign cnt_clr[C_FRM] = reg_rd & sel_fec;
   assign cnt_clr[C_CRC] = reg_rd & sel_cec;

   for (genvar c = 0; c < N_CNT; c++) begin : g_cnt
      t1_es_err_counter #(
         .CNT_W    (CNT_W),
         .SATURATE (SATURATE)
      ) cnt_i (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (cnt_inc[c]),
         .clr   (cnt_clr[c]),
         .cnt   (cnt_q[c])
      );
   end

   // mask and enable registers
   logic [N_SRC-1:0] mask_q;
   logic [N_IRQ-1:0] ien_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         ien_q  <= '0;
      end else if (reg_wr) begin
         if (sel_mask) mask_q <= reg_wdata[N_SRC-1:0];
         if (sel_ien)  ien_q  <= reg_wdata[N_IRQ-1:0];
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata[DATA_W-1:(N_SRC < N_IRQ ? N_SRC : N_IRQ)];

   // errored-second accumulation
   logic [N_SRC-1:0] es_evt;
   logic             es_set;

   assign es_evt[EV_FRM] = frm_q;
   assign es_evt[EV_CRC] = crc_q;
   assign es_evt[EV_LOF] = lvl_lof;
   assign es_evt[EV_LOS] = lvl_los;
   assign es_evt[EV_AIS] = lvl_ais;

   t1_es_accum #(.N_SRC(N_SRC)) accum_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (es_evt),
      .mask   (mask_q),
      .tick   (sec_tick),
      .es_set (es_set)
   );

   // status bits and interrupt
   logic [N_IRQ-1:0] st_set;
   logic [N_IRQ-1:0] st_clr;
   logic [N_IRQ-1:0] pending;

   assign st_set[ST_LOF] = lvl_lof;
   assign st_set[ST_LOS] = lvl_los;
   assign st_set[ST_AIS] = lvl_ais;
   assign st_set[ST_ES]  = es_set;

   generate
      if (SEC_IRQ_EN) begin : g_sec_on
         assign st_set[ST_SEC] = sec_tick;
      end else begin : g_sec_off
         assign st_set[ST_SEC] = 1'b0;
      end
   endgenerate

   assign st_clr = (reg_wr & sel_stat) ? reg_wdata[N_IRQ-1:0] : '0;

   t1_es_irq_ctrl #(.N_IRQ(N_IRQ)) irq_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (st_set),
      .clr     (st_clr),
      .en      (ien_q),
      .pending (pending),
      .irq     (irq)
   );

   // read path
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;

   always_comb begin
      rd_mux = '0;
      if (sel_fec)       rd_mux = DATA_W'(cnt_q[C_FRM]);
      else if (sel_cec)  rd_mux = DATA_W'(cnt_q[C_CRC]);
      else if (sel_mask) rd_mux = DATA_W'(mask_q);
      else if (sel_ien)  rd_mux = DATA_W'(ien_q);
      else if (sel_stat) rd_mux = DATA_W'(pending);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (reg_rd) rdata_q <= rd_mux;
   end

   assign reg_rdata = rdata_q;
endmodule

// File: rtl/t1_es_monitor_chk.sv
module t1_es_monitor_chk #(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_sync,
   input logic              esf_mode,
   input logic              sec_tick,
   input logic              lvl_lof,
   input logic              evt_frm_err,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [CNT_W-1:0]  fec_cnt,
   input logic [CNT_W-1:0]  cec_cnt,
   input logic [4:0]        pending
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   logic rd_fec, rd_cec;
   assign rd_fec = reg_rd && (reg_addr == ADDR_W'(0));
   assign rd_cec = reg_rd && (reg_addr == ADDR_W'(1));

   // R3: no counting while out of frame
   p_async_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_sync && !rd_fec) |=> $stable(fec_cnt));

   // R2: CRC counter idle in SF mode
   p_crc_sf_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!esf_mode && !rd_cec) |=> $stable(cec_cnt));

   // R4: saturation
   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fec_cnt == CMAX && !rd_fec) |=> (fec_cnt == CMAX));

   // R5: read clears when no event competes
   p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fec && !evt_frm_err) |=> (fec_cnt == '0));

   // R6: LOF sets its status bit
   p_lof_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_lof |=> pending[0]);

   // R7: ES bit only rises at a tick
   p_es_at_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_tick) |=> !$rose(pending[3]));

   // R8: tick sets one-second bit
   p_sec_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> pending[4]);
endmodule

bind t1_es_monitor t1_es_monitor_chk #(
   .CNT_W  (CNT_W),
   .ADDR_W (ADDR_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_sync     (in_sync),
   .esf_mode    (esf_mode),
   .sec_tick    (sec_tick),
   .lvl_lof     (lvl_lof),
   .evt_frm_err (evt_frm_err),
   .reg_rd      (reg_rd),
   .reg_addr    (reg_addr),
   .fec_cnt     (cnt_q[0]),
   .cec_cnt     (cnt_q[1]),
   .pending     (pending)
);

// File: tb/t1_es_monitor_tb_top.sv
module t1_es_monitor_tb_top;
   localparam int CNT_W  = 4;
   localparam int DATA_W = 16;
   localparam int ADDR_W = 3;
   localparam int CMAX   = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic evt_frm_err = 0, evt_crc_err = 0, lvl_lof = 0, lvl_los = 0, lvl_ais = 0;
   logic in_sync = 1, esf_mode = 1, sec_tick = 0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic reg_wr = 0, reg_rd = 0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic irq;

   int n_cmp = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   t1_es_monitor #(
      .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .SATURATE(1'b1), .SEC_IRQ_EN(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .evt_frm_err(evt_frm_err), .evt_crc_err(evt_crc_err),
      .lvl_lof(lvl_lof), .lvl_los(lvl_los), .lvl_ais(lvl_ais),
      .in_sync(in_sync), .esf_mode(esf_mode), .sec_tick(sec_tick),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   // reference model state
   int m_fec = 0, m_cec = 0, m_mask = 0, m_ien = 0, m_stat = 0;
   bit m_seen = 0;

   function automatic int sat_inc(int v);
      return (v == CMAX) ? v : v + 1;
   endfunction

   function automatic int read_model(int a);
      case (a)
         0: return m_fec;
         1: return m_cec;
         2: return m_mask;
         3: return m_ien;
         4: return m_stat;
         default: return 0;
      endcase
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic idle();
      evt_frm_err = 0; evt_crc_err = 0; lvl_lof = 0; lvl_los = 0; lvl_ais = 0;
      sec_tick = 0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
   endtask

   // one clock: model update from current inputs, then compare
   task automatic step(input string tag, input bit chk_irq);
      int a, rexp, evt, setv, clrv;
      bit fq, cq, rd, tk;
      a    = int'(reg_addr);
      rd   = reg_rd;
      tk   = sec_tick;
      rexp = read_model(a);
      fq   = evt_frm_err & in_sync;
      cq   = evt_crc_err & in_sync & esf_mode;
      evt  = ({27'd0, lvl_ais, lvl_los, lvl_lof, cq, fq}) & m_mask;
      setv = {27'd0, 1'b0, 1'b0, lvl_ais, lvl_los, lvl_lof};
      if (tk) setv |= 16;
      if (tk && (m_seen || evt != 0)) setv |= 8;
      clrv = (reg_wr && a == 4) ? int'(reg_wdata[4:0]) : 0;
      @(posedge clk);
      #1;
      m_fec  = (rd && a == 0) ? int'(fq) : (fq ? sat_inc(m_fec) : m_fec);
      m_cec  = (rd && a == 1) ? int'(cq) : (cq ? sat_inc(m_cec) : m_cec);
      m_stat = (m_stat & ~clrv) | setv;
      m_seen = tk ? 1'b0 : (m_seen || evt != 0);
      if (reg_wr && a == 2) m_mask = int'(reg_wdata[4:0]);
      if (reg_wr && a == 3) m_ien  = int'(reg_wdata[4:0]);
      if (rd) check({tag, " rdata"}, int'(reg_rdata), rexp);
      if (chk_irq) check({tag, " irq R10"}, int'(irq), int'((m_stat & m_ien) != 0));
   endtask

   task automatic rd_reg(input int a, input string tag);
      idle(); reg_rd = 1; reg_addr = ADDR_W'(a);
      step(tag, 1);
      idle();
   endtask

   task automatic wr_reg(input int a, input int d, input string tag);
      idle(); reg_wr = 1; reg_addr = ADDR_W'(a); reg_wdata = DATA_W'(d);
      step(tag, 1);
      idle();
   endtask

   // watchdog
   initial begin
      #400000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'h5EED1234);
      idle();
      repeat (3) @(posedge clk);
      #1;
      // R11 reset state
      check("R11 irq at reset", int'(irq), 0);
      check("R11 rdata at reset", int'(reg_rdata), 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      for (int a = 0; a < 6; a++) rd_reg(a, "R11 reset reg");

      // R1 framing counts in SF and ESF
      in_sync = 1; esf_mode = 0;
      for (int i = 0; i < 3; i++) begin idle(); evt_frm_err = 1; step("R1 sf", 1); end
      esf_mode = 1;
      for (int i = 0; i < 2; i++) begin idle(); evt_frm_err = 1; step("R1 esf", 1); end
      rd_reg(0, "R1 fec=5");

      // R2 CRC only in ESF
      esf_mode = 0;
      for (int i = 0; i < 4; i++) begin idle(); evt_crc_err = 1; step("R2 sf", 1); end
      rd_reg(1, "R2 cec sf=0");
      esf_mode = 1;
      for (int i = 0; i < 3; i++) begin idle(); evt_crc_err = 1; step("R2 esf", 1); end
      rd_reg(1, "R2 cec esf=3");

      // R3 asynchronous blocks counting
      in_sync = 0;
      for (int i = 0; i < 4; i++) begin
         idle(); evt_frm_err = 1; evt_crc_err = 1; step("R3 async", 1);
      end
      rd_reg(0, "R3 fec async");
      rd_reg(1, "R3 cec async");
      in_sync = 1;

      // R4 saturation
      for (int i = 0; i < CMAX + 5; i++) begin idle(); evt_frm_err = 1; step("R4 sat", 1); end
      rd_reg(0, "R4 fec saturated");

      // R5 read coinciding with event keeps it
      idle(); evt_frm_err = 1; step("R5 pre", 1);
      idle(); evt_frm_err = 1; reg_rd = 1; reg_addr = 0; step("R5 read+evt", 1);
      rd_reg(0, "R5 fec=1 after");

      // R6 alarms set status
      idle(); lvl_lof = 1; step("R6 lof", 1);
      idle(); lvl_ais = 1; step("R6 ais", 1);
      rd_reg(4, "R6 status");
      // R9 W1C with set winning
      idle(); lvl_lof = 1; reg_wr = 1; reg_addr = 4; reg_wdata = 16'h1F; step("R9 set wins", 1);
      rd_reg(4, "R9 status after clr");
      wr_reg(4, 16'h1F, "R9 clear all");
      rd_reg(4, "R9 status zero");

      // R7 / R8 errored second and one-second
      wr_reg(3, 16'h18, "R10 enable es+sec");
      wr_reg(2, 16'h08, "R7 mask los");
      idle(); lvl_lof = 1; step("R7 unmasked lof", 1);
      idle(); sec_tick = 1; step("R8 tick", 1);
      rd_reg(4, "R7 no es");
      wr_reg(4, 16'h1F, "R9 clr");
      idle(); lvl_los = 1; step("R7 los", 1);
      repeat (3) begin idle(); step("R7 gap", 1); end
      idle(); sec_tick = 1; step("R7 tick", 1);
      rd_reg(4, "R7 es set");
      wr_reg(4, 16'h1F, "R9 clr");
      idle(); sec_tick = 1; step("R7 restart", 1);
      rd_reg(4, "R7 fresh second");
      wr_reg(2, 16'h01, "R7 mask frm");
      in_sync = 0;
      idle(); evt_frm_err = 1; sec_tick = 1; step("R7 async frm", 1);
      in_sync = 1;
      idle(); evt_frm_err = 1; sec_tick = 1; step("R7 frm at tick", 1);
      rd_reg(4, "R7 es by tick-cycle frm");
      rd_reg(0, "R1 fec drain");

      // constrained random
      for (int cyc = 0; cyc < 4000; cyc++) begin
         int r;
         idle();
         if (cyc % 300 == 0) esf_mode = $urandom % 2;
         in_sync     = ($urandom % 8) != 0;
         evt_frm_err = ($urandom % 3) == 0;
         evt_crc_err = ($urandom % 4) == 0;
         lvl_lof     = ($urandom % 20) == 0;
         lvl_los     = ($urandom % 25) == 0;
         lvl_ais     = ($urandom % 30) == 0;
         sec_tick    = (cyc % 50) == 49;
         r = $urandom % 12;
         if (r < 2) begin
            reg_rd = 1; reg_addr = ADDR_W'($urandom % 6);
         end else if (r == 2) begin
            reg_wr = 1; reg_addr = ADDR_W'(2 + $urandom % 3);
            reg_wdata = DATA_W'($urandom);
         end
         step("R1/R2/R3/R4/R5/R6/R7/R8/R9 random", 1);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule